// File: doc/BRIEF.md
# Split-Capable Load-Store Unit

This block takes at most one decoded memory operation per clock and runs it on a word-wide data memory port. Each operation carries:

- its direction and access size;
- a sign-extension flag;
- a base address and an offset;
- the store register value, with the byte position of the datum inside that register;
- a post-increment flag.

The unit works out the access address and the lane enables. It moves store bytes onto their lanes. It returns loaded data, sign- or zero-extended, and it produces an updated base address whenever post-increment addressing is requested.

An access that crosses a word boundary is issued as two word transactions on consecutive cycles. While the first half is on the bus, the unit raises a busy flag so that the pipeline in front of it holds its next operation. For a load, the bytes of the two read words are joined before extension, and the result appears once, after the second word returns.

The memory port has no handshake. It accepts a request in the cycle it is driven, and it returns read data in the following cycle.

Top module: `lsu_split`

## Requirements
- R1: While reset is high and after it is released with no request, every output is driven to zero.
- R2: The bus address always has its two low bits at zero. The lane enables depend on the size code: 2'b00 (word) enables four bytes, 2'b01 (halfword) enables two bytes and 2'b10 (byte) enables one byte. The enabled bytes start at lane address[1:0], and the lanes that fall beyond lane 3 go to the second transaction.
- R3: With the post-increment flag clear, the access address is base plus offset and `wb_valid` stays low.
- R4: With the post-increment flag set, the first transaction uses the unmodified base. `wb_valid` is high in that same cycle, with `wb_addr` equal to base plus offset.
- R5: A halfword at address[1:0] = 3, or a word at any nonzero address[1:0], is split into two transactions. The second transaction is on the bus in the cycle right after the first, at the first word address plus 4. `misal_busy` is high exactly in the cycle the first transaction is on the bus.
- R6: The second transaction of a split access never asserts `wb_valid`, even with post-increment.
- R7: For a store, `mem_we` is high, and register byte `req_wofs` lands on lane address[1:0]. The other register bytes follow in rotating order, as a left rotation by (address[1:0] - `req_wofs`) mod 4. Both halves of a split store carry the same data word. A load drives `mem_we` low and write data zero.
- R8: Read data is sampled in the cycle after each read transaction. `ld_valid` pulses for one cycle, two cycles after the last read transaction of the load is on the bus.
- R9: A byte or halfword load is sign-extended when `req_sext` is set and zero-extended otherwise. A word load is returned whole. Byte k of the result is the memory byte at access address + k.
- R10: A request is accepted only when `hold` is low and `misal_busy` is low. `hold` does not stop the second half of a split access that is already under way.
- R11: A request with size code 2'b11 is ignored: no transaction, no write-back.
- R12: A split load joins the bytes from both read words into one result, delivered with a single `ld_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Decoded memory operation present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 word, 01 halfword, 10 byte, 11 invalid |
| req_sext | input | 1 | Sign-extend a narrow load result |
| req_base | input | ADDR_W | Base address |
| req_offset | input | ADDR_W | Address offset |
| req_wdata | input | 32 | Store register value |
| req_wofs | input | 2 | Byte position of the store datum inside the register |
| req_postinc | input | 1 | Post-increment addressing |
| hold | input | 1 | Upstream stall, blocks acceptance of a new operation |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| wb_valid | output | 1 | Base-register write-back valid |
| wb_addr | output | ADDR_W | Updated base address |
| misal_busy | output | 1 | Split access in progress, hold the next operation |

## Verification
A sequencer stuck in its second-half state shows up at once as an extra bus request, or as a request ignored in the next cycle. An offset or size held wrongly in the response context stays hidden on the bus. It only shows in `ld_data`, two cycles after the read went out, and only for narrow or straddling loads, so those are driven across every address alignment. A lost or stale first word shows as wrongly joined upper bytes in a split load's single result pulse. Any slip in lane enables or in the store rotation is visible on the same cycle's `mem_be` and `mem_wdata`.

// File: rtl/lsu_split_pkg.sv
package lsu_split_pkg;

  localparam int XLEN  = 32;
  localparam int NB    = XLEN / 8;
  localparam int OFS_W = $clog2(NB);

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_HALF = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_BAD  = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    PART_WHOLE = 2'd0,
    PART_LOW   = 2'd1,
    PART_HIGH  = 2'd2
  } part_e;

  // Context of a read that is on the bus, consumed when its data returns
  typedef struct packed {
    logic             valid;
    part_e            part;
    acc_size_e        size;
    logic             sext;
    logic [OFS_W-1:0] lo;
  } rsp_ctx_t;

  // Lane j receives byte (j - k) mod NB
  function automatic logic [XLEN-1:0] rotl_bytes(input logic [XLEN-1:0] w,
                                                 input logic [OFS_W-1:0] k);
    logic [XLEN-1:0]  r;
    logic [OFS_W-1:0] src;
    r = '0;
    for (int j = 0; j < NB; j++) begin
      src = OFS_W'(j) - k;
      r[8*j +: 8] = w[8*int'(src) +: 8];
    end
    return r;
  endfunction

  // Byte j receives lane (j + k) mod NB
  function automatic logic [XLEN-1:0] rotr_bytes(input logic [XLEN-1:0] w,
                                                 input logic [OFS_W-1:0] k);
    logic [XLEN-1:0]  r;
    logic [OFS_W-1:0] src;
    r = '0;
    for (int j = 0; j < NB; j++) begin
      src = OFS_W'(j) + k;
      r[8*j +: 8] = w[8*int'(src) +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  input  logic          post_inc,
  output logic [AW-1:0] access_addr,
  output logic [AW-1:0] next_base
);

  assign next_base   = base + offset;
  assign access_addr = post_inc ? base : next_base;

endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
  import lsu_split_pkg::*;
(
  input  acc_size_e        size,
  input  logic [OFS_W-1:0] lo,
  input  logic [XLEN-1:0]  st_data,
  input  logic [OFS_W-1:0] st_ofs,
  output logic [NB-1:0]    be_first,
  output logic [NB-1:0]    be_second,
  output logic             straddle,
  output logic [XLEN-1:0]  bus_data
);

  localparam int SPAN = 2 * NB;
  localparam int PW   = OFS_W + 2;

  logic [PW-1:0]   nbytes;
  logic [PW-1:0]   lo_w;
  logic [PW-1:0]   end_w;
  logic [SPAN-1:0] span_en;

  always_comb begin
    case (size)
      SZ_WORD: nbytes = PW'(NB);
      SZ_HALF: nbytes = PW'(2);
      SZ_BYTE: nbytes = PW'(1);
      default: nbytes = '0;
    endcase
  end

  assign lo_w  = PW'(lo);
  assign end_w = lo_w + nbytes;

  // Lane window over two consecutive words
  for (genvar g = 0; g < SPAN; g++) begin : g_span
    assign span_en[g] = (lo_w <= PW'(g)) && (PW'(g) < end_w);
  end

  assign be_first  = span_en[NB-1:0];
  assign be_second = span_en[SPAN-1:NB];
  assign straddle  = |be_second;
  assign bus_data  = rotl_bytes(st_data, lo - st_ofs);

endmodule

// File: rtl/lsu_load_merge.sv
module lsu_load_merge
  import lsu_split_pkg::*;
(
  input  rsp_ctx_t        ctx,
  input  logic [XLEN-1:0] low_word,
  input  logic [XLEN-1:0] cur_word,
  output logic [XLEN-1:0] value
);

  localparam int CW = OFS_W + 1;

  logic [XLEN-1:0] rot_low;
  logic [XLEN-1:0] rot_cur;
  logic [XLEN-1:0] joined;
  logic [CW-1:0]   keep_low;

  assign rot_low  = rotr_bytes(low_word, ctx.lo);
  assign rot_cur  = rotr_bytes(cur_word, ctx.lo);
  assign keep_low = CW'(NB) - CW'(ctx.lo);

  // Bytes below keep_low came from the first word of a split read
  for (genvar g = 0; g < NB; g++) begin : g_join
    assign joined[8*g +: 8] = ((ctx.part == PART_HIGH) && (CW'(g) < keep_low))
                              ? rot_low[8*g +: 8] : rot_cur[8*g +: 8];
  end

  always_comb begin
    case (ctx.size)
      SZ_BYTE: value = ctx.sext ? {{(XLEN-8){joined[7]}}, joined[7:0]}
                                : {{(XLEN-8){1'b0}}, joined[7:0]};
      SZ_HALF: value = ctx.sext ? {{(XLEN-16){joined[15]}}, joined[15:0]}
                                : {{(XLEN-16){1'b0}}, joined[15:0]};
      default: value = joined;
    endcase
  end

endmodule

// File: rtl/lsu_split.sv
module lsu_split
  import lsu_split_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_sext,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [31:0]       req_wdata,
  input  logic [1:0]        req_wofs,
  input  logic              req_postinc,
  input  logic              hold,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              ld_valid,
  output logic [31:0]       ld_data,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              misal_busy
);

  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(NB);

  typedef enum logic {ST_IDLE, ST_SECOND} seq_e;

  seq_e              st;
  acc_size_e         size_in;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] sum_addr;
  logic [ADDR_W-1:0] word_addr;
  logic [NB-1:0]     be_first;
  logic [NB-1:0]     be_second;
  logic              straddle;
  logic [XLEN-1:0]   bus_data;
  logic [XLEN-1:0]   load_value;
  logic [XLEN-1:0]   low_word;
  logic              accept;
  rsp_ctx_t          first_ctx;
  rsp_ctx_t          second_ctx;
  rsp_ctx_t          bus_ctx;
  rsp_ctx_t          rsp_ctx;
  logic [ADDR_W-1:0] sec_addr;
  logic [NB-1:0]     sec_be;
  logic [XLEN-1:0]   sec_wdata;
  logic              sec_we;
  rsp_ctx_t          sec_ctx;

  assign size_in = acc_size_e'(req_size);

  lsu_agen #(.AW(ADDR_W)) u_agen (
    .base        (req_base),
    .offset      (req_offset),
    .post_inc    (req_postinc),
    .access_addr (eff_addr),
    .next_base   (sum_addr)
  );

  lsu_lane_map u_lanes (
    .size      (size_in),
    .lo        (eff_addr[OFS_W-1:0]),
    .st_data   (req_wdata),
    .st_ofs    (req_wofs),
    .be_first  (be_first),
    .be_second (be_second),
    .straddle  (straddle),
    .bus_data  (bus_data)
  );

  lsu_load_merge u_merge (
    .ctx      (rsp_ctx),
    .low_word (low_word),
    .cur_word (mem_rdata),
    .value    (load_value)
  );

  assign word_addr = {eff_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign accept    = (st == ST_IDLE) && req_valid && !hold && (size_in != SZ_BAD);

  always_comb begin
    first_ctx.valid  = !req_write;
    first_ctx.part   = straddle ? PART_LOW : PART_WHOLE;
    first_ctx.size   = size_in;
    first_ctx.sext   = req_sext;
    first_ctx.lo     = eff_addr[OFS_W-1:0];
    second_ctx       = first_ctx;
    second_ctx.part  = PART_HIGH;
  end

  // Issue sequencer: first part on acceptance, second part on the next edge
  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
      wb_valid   <= 1'b0;
      wb_addr    <= '0;
      misal_busy <= 1'b0;
      bus_ctx    <= '0;
      sec_addr   <= '0;
      sec_be     <= '0;
      sec_wdata  <= '0;
      sec_we     <= 1'b0;
      sec_ctx    <= '0;
    end else begin
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
      wb_valid   <= 1'b0;
      misal_busy <= 1'b0;
      bus_ctx    <= '0;
      if (st == ST_SECOND) begin
        st        <= ST_IDLE;
        mem_req   <= 1'b1;
        mem_we    <= sec_we;
        mem_addr  <= sec_addr;
        mem_be    <= sec_be;
        mem_wdata <= sec_we ? sec_wdata : '0;
        bus_ctx   <= sec_ctx;
      end else if (accept) begin
        mem_req   <= 1'b1;
        mem_we    <= req_write;
        mem_addr  <= word_addr;
        mem_be    <= be_first;
        mem_wdata <= req_write ? bus_data : '0;
        wb_valid  <= req_postinc;
        wb_addr   <= sum_addr;
        bus_ctx   <= first_ctx;
        if (straddle) begin
          st         <= ST_SECOND;
          misal_busy <= 1'b1;
          sec_addr   <= word_addr + WORD_STEP;
          sec_be     <= be_second;
          sec_wdata  <= bus_data;
          sec_we     <= req_write;
          sec_ctx    <= second_ctx;
        end
      end
    end
  end

  // Read return path: one cycle behind the bus
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ctx  <= '0;
      low_word <= '0;
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      rsp_ctx  <= bus_ctx;
      ld_valid <= 1'b0;
      ld_data  <= '0;
      if (rsp_ctx.valid) begin
        if (rsp_ctx.part == PART_LOW) begin
          low_word <= mem_rdata;
        end else begin
          ld_valid <= 1'b1;
          ld_data  <= load_value;
        end
      end
    end
  end

endmodule

// File: rtl/lsu_split_chk.sv
module lsu_split_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              hold,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic [31:0]       mem_wdata,
  input logic              ld_valid,
  input logic              wb_valid,
  input logic              misal_busy
);

  assert_second_next_word_R5: assert property (@(posedge clk) disable iff (rst)
    misal_busy |=> mem_req && (mem_addr == $past(mem_addr) + ADDR_W'(4)));

  assert_busy_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    misal_busy |=> !misal_busy);

  assert_no_wb_second_R6: assert property (@(posedge clk) disable iff (rst)
    misal_busy |=> !wb_valid);

  assert_aligned_bus_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00) && (mem_be != 4'b0000));

  assert_hold_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    hold && !misal_busy |=> !mem_req);

  assert_wb_with_bus_R4: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> mem_req);

  assert_load_no_wdata_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_we |-> mem_wdata == 32'h0);

  assert_load_timing_R8: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(mem_req, 2) && !$past(mem_we, 2));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !mem_req |-> (mem_be == 4'b0000) && !mem_we);

endmodule

bind lsu_split lsu_split_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hold       (hold),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .mem_wdata  (mem_wdata),
  .ld_valid   (ld_valid),
  .wb_valid   (wb_valid),
  .misal_busy (misal_busy)
);

// File: tb/lsu_split_test.sv
module lsu_split_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [1:0]    req_size = 2'b00;
  logic          req_sext = 1'b0;
  logic [AW-1:0] req_base = '0;
  logic [AW-1:0] req_offset = '0;
  logic [31:0]   req_wdata = '0;
  logic [1:0]    req_wofs = 2'b00;
  logic          req_postinc = 1'b0;
  logic          hold = 1'b0;
  logic          mem_req, mem_we, ld_valid, wb_valid, misal_busy;
  logic [AW-1:0] mem_addr, wb_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata, ld_data;
  logic [31:0]   mem_rdata = 32'h0;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_split #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_sext(req_sext), .req_base(req_base),
    .req_offset(req_offset), .req_wdata(req_wdata), .req_wofs(req_wofs),
    .req_postinc(req_postinc), .hold(hold), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .misal_busy(misal_busy)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    logic [31:0] w;
    w = mem_word({a[31:2], 2'b00});
    return w[8*int'(a[1:0]) +: 8];
  endfunction

  // Memory: read data one cycle after a read request
  always @(posedge clk)
    mem_rdata <= (mem_req && !mem_we) ? mem_word(mem_addr) : 32'hA5A5_5A5A;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model state
  bit          live = 0;
  int          cyc = 0;
  bit          e_req, e_we, e_wbv, e_busy, e_ldv;
  logic [31:0] e_addr, e_wdata, e_wba, e_ldd;
  logic [3:0]  e_be;
  bit          sp = 0;
  bit          s_we, s_ld;
  logic [31:0] s_addr, s_wdata, s_ldv;
  logic [3:0]  s_be;
  int          ldq_cyc[$];
  logic [31:0] ldq_val[$];

  always @(posedge clk) begin
    live = 1;
    cyc++;
    e_req = 0; e_we = 0; e_addr = 0; e_be = 0; e_wdata = 0;
    e_wbv = 0; e_busy = 0; e_ldv = 0; e_ldd = 0;
    if (rst) begin
      sp = 0; e_wba = 0;
      ldq_cyc.delete(); ldq_val.delete();
    end else begin
      if (sp) begin
        sp = 0;
        e_req = 1; e_we = s_we; e_addr = s_addr; e_be = s_be;
        e_wdata = s_we ? s_wdata : 32'h0;
        if (s_ld) begin ldq_cyc.push_back(cyc + 2); ldq_val.push_back(s_ldv); end
      end else if (req_valid && !hold && req_size != 2'b11) begin
        int n;
        logic [31:0] ea, a, v, wd, msk;
        logic [3:0]  b1, b2;
        n  = (req_size == 2'b00) ? 4 : (req_size == 2'b01) ? 2 : 1;
        ea = req_postinc ? req_base : req_base + req_offset;
        b1 = 0; b2 = 0; v = 0; wd = 0;
        for (int k = 0; k < n; k++) begin
          a = ea + k;
          if (a[31:2] == ea[31:2]) b1[a[1:0]] = 1'b1; else b2[a[1:0]] = 1'b1;
          v[8*k +: 8] = mem_byte(a);
        end
        if (n < 4 && req_sext && v[8*n-1]) begin
          msk = (32'h1 << (8*n)) - 1;
          v = v | ~msk;
        end
        for (int b = 0; b < 4; b++)
          wd[8*((b - int'(req_wofs) + int'(ea[1:0])) & 3) +: 8] = req_wdata[8*b +: 8];
        e_req = 1; e_we = req_write; e_addr = {ea[31:2], 2'b00}; e_be = b1;
        e_wdata = req_write ? wd : 32'h0;
        e_wbv = req_postinc; e_wba = req_base + req_offset;
        if (b2 != 0) begin
          sp = 1; e_busy = 1;
          s_we = req_write; s_ld = !req_write; s_addr = e_addr + 4;
          s_be = b2; s_wdata = wd; s_ldv = v;
        end else if (!req_write) begin
          ldq_cyc.push_back(cyc + 2); ldq_val.push_back(v);
        end
      end
      if (ldq_cyc.size() > 0 && ldq_cyc[0] == cyc) begin
        e_ldv = 1; e_ldd = ldq_val[0];
        void'(ldq_cyc.pop_front()); void'(ldq_val.pop_front());
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      chk(mem_req === e_req, "R10 R11 mem_req", 32'(mem_req), 32'(e_req));
      chk(mem_we === e_we, "R7 mem_we", 32'(mem_we), 32'(e_we));
      chk(mem_addr === e_addr, "R3 R5 mem_addr", mem_addr, e_addr);
      chk(mem_be === e_be, "R2 R5 mem_be", 32'(mem_be), 32'(e_be));
      chk(mem_wdata === e_wdata, "R7 mem_wdata", mem_wdata, e_wdata);
      chk(wb_valid === e_wbv, "R3 R4 R6 wb_valid", 32'(wb_valid), 32'(e_wbv));
      if (e_wbv) chk(wb_addr === e_wba, "R4 wb_addr", wb_addr, e_wba);
      chk(misal_busy === e_busy, "R5 misal_busy", 32'(misal_busy), 32'(e_busy));
      chk(ld_valid === e_ldv, "R8 ld_valid", 32'(ld_valid), 32'(e_ldv));
      if (e_ldv) chk(ld_data === e_ldd, "R9 R12 ld_data", ld_data, e_ldd);
    end
  end

  task automatic op(input bit wr, input logic [1:0] sz, input bit sx,
                    input logic [31:0] b, input logic [31:0] o,
                    input logic [31:0] wd, input logic [1:0] wo, input bit pi);
    @(negedge clk);
    req_write = wr; req_size = sz; req_sext = sx; req_base = b;
    req_offset = o; req_wdata = wd; req_wofs = wo; req_postinc = pi;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_req && !mem_we && mem_be == 0 && mem_wdata == 0, "R1 bus idle in reset",
        {mem_req, mem_we, mem_be}, 0);
    chk(!ld_valid && ld_data == 0 && !wb_valid && !misal_busy, "R1 status idle in reset",
        {ld_valid, wb_valid, misal_busy}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!mem_req && !wb_valid && wb_addr == 0, "R1 idle after reset", 32'(mem_req), 0);

    // Loads of every size and alignment, both extension modes
    for (int lo = 0; lo < 4; lo++) begin
      for (int sz = 0; sz < 3; sz++) begin
        op(0, 2'(sz), 1, 32'h100, 32'(lo), 0, 0, 0);
        op(0, 2'(sz), 0, 32'h204 + 32'(lo), 32'h10, 0, 0, 1);
      end
    end
    // Stores with every register byte position
    for (int lo = 0; lo < 4; lo++)
      for (int wo = 0; wo < 4; wo++) begin
        op(1, 2'b00, 0, 32'h300, 32'(lo), 32'h1122_3344, 2'(wo), 0);
        op(1, 2'b01, 0, 32'h400 + 32'(lo), 32'h8, 32'hA1B2_C3D4, 2'(wo), 1);
        op(1, 2'b10, 0, 32'h500, 32'(lo), 32'hCAFE_F00D, 2'(wo), 0);
      end
    // Negative offset with post-increment on a split word (R6)
    op(0, 2'b00, 0, 32'h603, 32'hFFFF_FFF0, 0, 0, 1);
    // Invalid size code ignored (R11)
    op(0, 2'b11, 1, 32'h700, 0, 0, 0, 1);
    // Hold blocks acceptance (R10)
    hold = 1'b1;
    op(1, 2'b00, 0, 32'h800, 0, 32'hFFFF_FFFF, 0, 1);
    hold = 1'b0;
    // Back-to-back requests across a split, hold during second half (R10)
    @(negedge clk);
    req_write = 0; req_size = 2'b00; req_sext = 0; req_base = 32'h901;
    req_offset = 0; req_postinc = 0; req_valid = 1;
    @(negedge clk);
    hold = 1'b1; req_base = 32'h910;
    @(negedge clk);
    hold = 1'b0;
    @(negedge clk);
    req_valid = 0;
    repeat (4) @(negedge clk);

    // Mixed traffic
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      req_valid   = ($urandom % 10) < 7;
      hold        = ($urandom % 5) == 0;
      req_write   = $urandom % 2;
      req_size    = 2'($urandom % 4);
      req_sext    = $urandom % 2;
      req_base    = $urandom % 2048;
      req_offset  = ($urandom % 128) - 64;
      req_wdata   = $urandom;
      req_wofs    = 2'($urandom % 4);
      req_postinc = $urandom % 2;
    end
    @(negedge clk);
    req_valid = 0; hold = 0;
    repeat (6) @(negedge clk);
    summary();
    $finish;
  end

endmodule